// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM burst, one per clock. A start strobe gives it a starting column, a three-bit length code and an ordering bit. From the next cycle on it steps through the burst in sequential or interleaved order, and it flags the final beat. A full-page burst has no final beat. It keeps running, wrapping around the whole row, until it is stopped.

A memory controller drives the strobes from its command decoder. A start carries a fresh length and ordering choice. A restart models a new read or write that reuses the length and ordering already in force, so only a new column is needed. A stop models a burst-terminate request. Start and restart may arrive on any cycle, including in the middle of a burst, and they win over a stop given in the same cycle. An illegal length choice still yields a single beat, but it raises an error flag.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous reset, `beat_vld_o`, `last_o` and `mode_err_o` are all low.
- R2: With length codes 3'b000, 3'b001, 3'b010 and 3'b011, a start produces 1, 2, 4 and 8 beats on consecutive cycles. The first beat appears in the cycle after the strobe. `last_o` is high only on the final beat, and `beat_vld_o` is low afterwards.
- R3: With ordering bit 0 and a finite length of 2^k beats, the upper column bits stay equal to the start column. The low k bits count up from the start column's low bits and wrap within that aligned block (start 5 with length 4 gives 5, 6, 7, 4).
- R4: With ordering bit 1, beat number n carries the start column XORed with n in its low k bits (start 5 with length 8 gives 5, 4, 7, 6, 1, 0, 3, 2).
- R5: Code 3'b111 with ordering bit 0 is a full-page burst. The column increases by one each cycle modulo 512 (510, 511, 0, 1 and so on), and `last_o` never rises.
- R6: A stop ends the burst: `beat_vld_o` is low from the cycle after the stop. A stop while no burst runs leaves the outputs low.
- R7: A restart loads the column on `start_col_i` and starts again from beat 0. It keeps the length and ordering latched by the last start.
- R8: A start during a running burst abandons that burst at once and begins the new one with its own column, length and ordering.
- R9: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with ordering bit 1, give exactly one beat, with `last_o` and `mode_err_o` high. `mode_err_o` stays high until the next start with a legal choice.
- R10: When a start or a restart arrives in the same cycle as a stop, the stop is ignored and the new burst begins.
- R11: The first beat of every burst carries the start column, whatever the length and ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst with new length and ordering |
| restart_i | input | 1 | Begin a burst that reuses the latched length and ordering |
| stop_i | input | 1 | Terminate the running burst |
| start_col_i | input | 9 | Starting column for start or restart |
| len_code_i | input | 3 | Length code, sampled on start |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved, sampled on start |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | This beat is the final one of a finite burst |
| mode_err_o | output | 1 | The latched length choice is illegal |

## Verification
Sequential bursts start from both an aligned and a misaligned column, and one starts near the top of the row. This separates wrapping inside the block from carrying into the upper bits. Interleaved bursts use starting columns whose low bits differ, which separates XOR ordering from addition with wrap. A full-page burst that crosses column 511 shows the modulo-512 wrap and the absence of a final beat. Stops, restarts, preempting starts and strobes that coincide with a stop are placed in mid-burst, so that priority and the reuse of latched length against fresh length can be told apart.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int COL_W = 9;
    localparam int LG_W  = $clog2(COL_W + 1);

    localparam logic [2:0] CODE_PAGE = 3'b111;

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic [LG_W-1:0] lg;     // log2 of the burst length
        logic            page;   // full-page burst
        order_e          order;
        logic            bad;    // illegal choice, single beat
    } mode_t;

    localparam mode_t MODE_RESET = '{lg: '0, page: 1'b0, order: ORD_SEQ, bad: 1'b0};

    function automatic mode_t decode_mode(logic [2:0] code, logic ilv);
        mode_t m;
        m       = MODE_RESET;
        m.order = ilv ? ORD_XOR : ORD_SEQ;
        if (code[2] == 1'b0) begin
            m.lg = LG_W'(code[1:0]);
        end else if (code == CODE_PAGE && !ilv) begin
            m.page = 1'b1;
        end else begin
            m.bad = 1'b1;
        end
        return m;
    endfunction

    function automatic col_t span_mask(mode_t m);
        col_t r;
        if (m.page) r = '1;
        else        r = (col_t'(1) << m.lg) - col_t'(1);
        return r;
    endfunction

endpackage

// File: rtl/bseq_mode_latch.sv
module bseq_mode_latch
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [2:0] code_i,
    input  logic       ilv_i,
    output mode_t      mode_o,
    output col_t       mask_o
);
    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= MODE_RESET;
        else if (load_i) mode_q <= decode_mode(code_i, ilv_i);
    end

    assign mode_o = mode_q;
    assign mask_o = span_mask(mode_q);
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic stop_i,
    input  col_t mask_i,
    input  logic page_i,
    output col_t beat_o,
    output logic active_o,
    output logic last_o
);
    col_t beat_q;
    logic act_q;
    logic at_end;

    assign at_end = act_q && !page_i && (beat_q == mask_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            beat_q <= '0;
        end else if (load_i) begin
            act_q  <= 1'b1;
            beat_q <= '0;
        end else if (stop_i) begin
            act_q  <= 1'b0;
        end else if (act_q) begin
            beat_q <= beat_q + col_t'(1);
            if (at_end) act_q <= 1'b0;
        end
    end

    assign beat_o   = beat_q;
    assign active_o = act_q;
    assign last_o   = at_end;
endmodule

// File: rtl/bseq_col_gen.sv
module bseq_col_gen
    import bseq_pkg::*;
(
    input  col_t   base_i,
    input  col_t   beat_i,
    input  col_t   mask_i,
    input  order_e order_i,
    output col_t   col_o
);
    col_t sum;
    assign sum = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        logic moved;
        always_comb begin
            if (order_i == ORD_XOR) moved = base_i[i] ^ beat_i[i];
            else                    moved = sum[i];
        end
        assign col_o[i] = mask_i[i] ? moved : base_i[i];
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       restart_i,
    input  logic       stop_i,
    input  logic [8:0] start_col_i,
    input  logic [2:0] len_code_i,
    input  logic       ilv_i,
    output logic [8:0] col_o,
    output logic       beat_vld_o,
    output logic       last_o,
    output logic       mode_err_o
);
    logic  load;
    col_t  base_q;
    mode_t mode;
    col_t  mask;
    col_t  beat;

    assign load = start_i | restart_i;

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= start_col_i;
    end

    bseq_mode_latch u_mode (
        .clk    (clk),
        .rst    (rst),
        .load_i (start_i),
        .code_i (len_code_i),
        .ilv_i  (ilv_i),
        .mode_o (mode),
        .mask_o (mask)
    );

    bseq_beat_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .stop_i   (stop_i),
        .mask_i   (mask),
        .page_i   (mode.page),
        .beat_o   (beat),
        .active_o (beat_vld_o),
        .last_o   (last_o)
    );

    bseq_col_gen u_col (
        .base_i  (base_q),
        .beat_i  (beat),
        .mask_i  (mask),
        .order_i (mode.order),
        .col_o   (col_o)
    );

    assign mode_err_o = mode.bad;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       restart_i,
    input logic       stop_i,
    input logic [8:0] start_col_i,
    input logic [2:0] len_code_i,
    input logic       ilv_i,
    input logic [8:0] col_o,
    input logic       beat_vld_o,
    input logic       last_o,
    input logic       mode_err_o
);
    assert_last_is_beat_R2: assert property (@(posedge clk) disable iff (rst)
        last_o |-> beat_vld_o);

    assert_quiet_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i && !restart_i) |=> !beat_vld_o);

    assert_beats_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_vld_o && !last_o && !start_i && !restart_i && !stop_i) |=> beat_vld_o);

    assert_stop_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i && !restart_i) |=> !beat_vld_o);

    assert_load_beats_stop_R10: assert property (@(posedge clk) disable iff (rst)
        ((start_i || restart_i) && stop_i) |=> beat_vld_o);

    assert_first_col_R11: assert property (@(posedge clk) disable iff (rst)
        (start_i || restart_i) |=> (col_o == $past(start_col_i)));

    assert_bad_single_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && len_code_i[2] && !(len_code_i == 3'b111 && !ilv_i))
            |=> (mode_err_o && last_o));

    assert_page_no_last_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && len_code_i == 3'b111 && !ilv_i) |=> (!last_o && !mode_err_o));
endmodule

bind burst_col_seq bseq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .restart_i   (restart_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .ilv_i       (ilv_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o),
    .mode_err_o  (mode_err_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, restart_i = 1'b0, stop_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic [8:0] col_o;
    logic       beat_vld_o, last_o, mode_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .restart_i(restart_i),
        .stop_i(stop_i), .start_col_i(start_col_i), .len_code_i(len_code_i),
        .ilv_i(ilv_i), .col_o(col_o), .beat_vld_o(beat_vld_o),
        .last_o(last_o), .mode_err_o(mode_err_o)
    );

    typedef struct {
        logic       vld;
        logic [8:0] col;
        logic       last;
        logic       err;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // reference model state
    logic [8:0] m_base = '0;
    int         m_lg = 0;
    logic       m_page = 1'b0, m_ilv = 1'b0, m_err = 1'b0, m_act = 1'b0;
    int         m_beat = 0;

    function automatic logic [8:0] ref_col(int b);
        int len  = 1 << m_lg;
        int blk  = int'(m_base) - (int'(m_base) % len);
        int off  = int'(m_base) % len;
        if (m_page)     return 9'((int'(m_base) + b) % 512);
        else if (m_ilv) return m_base ^ 9'(b % len);
        else            return 9'(blk + (off + b) % len);
    endfunction

    // kind: 0 start, 1 restart, 2 stop, 3 start+stop, 4 restart+stop, 5 idle
    task automatic cmd(int kind, logic [8:0] col, logic [2:0] code, logic ilv, int run, string tag);
        start_i     = (kind == 0 || kind == 3);
        restart_i   = (kind == 1 || kind == 4);
        stop_i      = (kind == 2 || kind == 3 || kind == 4);
        start_col_i = col;
        len_code_i  = code;
        ilv_i       = ilv;
        if (start_i) begin
            m_ilv = ilv; m_page = 1'b0; m_err = 1'b0; m_lg = 0;
            if (code[2] == 1'b0) m_lg = int'(code[1:0]);
            else if (code == 3'b111 && !ilv) m_page = 1'b1;
            else m_err = 1'b1;
        end
        if (start_i || restart_i) begin
            m_base = col; m_act = 1'b1; m_beat = 0;
        end else if (stop_i) begin
            m_act = 1'b0;
        end
        for (int c = 0; c < run; c++) begin
            exp_t e;
            e.tag = tag; e.err = m_err;
            if (m_act) begin
                e.vld  = 1'b1;
                e.col  = ref_col(m_beat);
                e.last = !m_page && (m_beat == (1 << m_lg) - 1);
                if (e.last) m_act = 1'b0;
                m_beat++;
            end else begin
                e.vld = 1'b0; e.col = '0; e.last = 1'b0;
            end
            sb.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0; restart_i = 1'b0; stop_i = 1'b0;
        repeat (run - 1) @(negedge clk);
    endtask

    // monitor: one expected item per cycle, sampled a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (beat_vld_o !== e.vld || mode_err_o !== e.err ||
                    (e.vld && (col_o !== e.col || last_o !== e.last)) ||
                    (!e.vld && last_o !== 1'b0)) begin
                    n_bad++;
                    $display("FAIL %s: vld/col/last/err actual %0b/%0d/%0b/%0b expected %0b/%0d/%0b/%0b",
                             e.tag, beat_vld_o, col_o, last_o, mode_err_o,
                             e.vld, e.col, e.last, e.err);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_chk++;
        if (beat_vld_o !== 1'b0 || last_o !== 1'b0 || mode_err_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: vld/last/err actual %0b/%0b/%0b expected 0/0/0",
                     beat_vld_o, last_o, mode_err_o);
        end
        // R2: each legal finite length
        cmd(0, 9'd3,   3'b000, 1'b0, 2, "R2 len1");
        cmd(0, 9'd9,   3'b001, 1'b0, 3, "R2 len2");
        // R3: sequential wrap in aligned block
        cmd(0, 9'd5,   3'b010, 1'b0, 5, "R3 seq4 start5");
        cmd(0, 9'd510, 3'b011, 1'b0, 9, "R3 seq8 top");
        // R4: interleaved
        cmd(0, 9'd5,   3'b011, 1'b1, 9, "R4 xor8 start5");
        cmd(0, 9'd6,   3'b010, 1'b1, 5, "R4 xor4 start6");
        // R5 full page then R6 stop
        cmd(0, 9'd510, 3'b111, 1'b0, 6, "R5 page wrap");
        cmd(2, 9'd0,   3'b000, 1'b0, 3, "R6 stop mid");
        cmd(2, 9'd0,   3'b000, 1'b0, 2, "R6 stop idle");
        // R7: restart reuses latched mode
        cmd(0, 9'd100, 3'b011, 1'b0, 3, "R7 first");
        cmd(1, 9'd203, 3'b000, 1'b1, 9, "R7 restart");
        // R8: start preempts with new mode
        cmd(0, 9'd17,  3'b011, 1'b1, 2, "R8 first");
        cmd(0, 9'd40,  3'b001, 1'b0, 3, "R8 preempt");
        // R9: illegal choices
        cmd(0, 9'd7,   3'b100, 1'b0, 2, "R9 code100");
        cmd(0, 9'd8,   3'b110, 1'b0, 2, "R9 code110");
        cmd(0, 9'd9,   3'b111, 1'b1, 2, "R9 page xor");
        cmd(5, 9'd0,   3'b000, 1'b0, 2, "R9 err held");
        cmd(0, 9'd11,  3'b000, 1'b0, 2, "R9 err cleared");
        // R10: start/restart beat a same-cycle stop
        cmd(0, 9'd300, 3'b111, 1'b0, 3, "R10 page run");
        cmd(3, 9'd12,  3'b010, 1'b0, 5, "R10 start+stop");
        cmd(4, 9'd33,  3'b000, 1'b0, 5, "R10 restart+stop");
        // R11: first beat equals start column, interleaved misaligned
        cmd(0, 9'd255, 3'b011, 1'b1, 2, "R11 first xor");
        cmd(2, 9'd0,   3'b000, 1'b0, 2, "R11 stop");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule